// File: doc/BRIEF.md
# Linear Burst Bus Master with Address-Hold Handling

This block sequences the address side of a bus master that moves whole cache lines in linear bursts. Each request it accepts names a dword-aligned start address. The block opens the burst with an address cycle that pulses the strobe `as_o`. It then steps the low address by one dword, which is 4 bytes, for each beat that the slave acknowledges. The burst ends after the number of beats set by a 5-bit line-length code.

An external agent can take over the upper part of the address bus through the hold input. While hold is active, the bits chosen by the line-length code are released to high impedance through a registered per-bit output-enable mask. Data beats that are already under way keep running during the hold. Any new address cycle waits until the hold is released: a new burst, a burst whose first cycle was suspended, or a restart forced by the ready-return input.

Requests use a valid/ready handshake. `req_ready_o` is high when the sequencer is idle. It is also high in the cycle that carries the final beat of a burst, so a waiting request is taken with no gap. A request held with valid high and ready low stays pending, and the requester must keep its address stable until it is taken.

Top module: `lbm_top`

## Requirements
- R1: After reset the line-length code is 00100. A burst then has 4 beats, and a hold floats address bits 31 to 4.
- R2: Hold floats no bits for code 00000. It floats bits 31 to N for the legal codes, where N is 2, 3, 4, 5 or 6 for codes 00001, 00010, 00100, 01000 and 10000 respectively.
- R3: `addr_oe_o` is registered. The float starts on the clock edge after hold is sampled high, and full drive returns on the edge after hold is sampled low.
- R4: For a reserved code, and also for 00000, no address bit ever floats and every burst is a single beat.
- R5: A legal nonzero code gives a burst length equal to its value in beats, and `addr_o` (a dword address) increases by 1 on every accepted beat.
- R6: When hold rises during the data beats, the beats continue and the burst still ends after its full length.
- R7: `as_o` is never high while hold is high. A first address cycle that is suspended by hold keeps its address and pulses `as_o` in the cycle in which hold is low.
- R8: A request accepted on the final beat while hold is high keeps `cmd_o` high with `as_o` low until hold is released. The strobe then presents the new address.
- R9: Ready-return together with a beat that is not the last forces a new address cycle at the next address. Beats offered while that cycle waits for hold to be released are ignored.
- R10: `req_ready_o` is low during a burst except on its final beat. A request offered then is not taken and does not change `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Write enable for the line-length code |
| cfg_cll_i | input | 5 | New line-length code |
| req_valid_i | input | 1 | Burst request valid |
| req_ready_o | output | 1 | Burst request ready |
| req_addr_i | input | 30 | Start dword address (byte address bits 31:2) |
| hold_i | input | 1 | External address hold |
| beat_rdy_i | input | 1 | Slave acknowledges one data beat |
| rdy_ret_i | input | 1 | Ready-return: the next beat needs a new address cycle |
| as_o | output | 1 | Address strobe, high during an address cycle |
| cmd_o | output | 1 | Command signals driven (transfer in progress) |
| addr_o | output | 30 | Current dword address (bits 31:2) |
| addr_oe_o | output | 30 | Per-bit output enable for address bits 31:2 |

## Verification
The hardest case to reach is a ready-return that meets an active hold in the middle of a line. Hold and ready-return must both be high in the cycle of a non-final beat, and beats must keep arriving while the restart is stalled. The bench sets up exactly that cycle in a 4-beat burst. It then offers beats that must be ignored, and checks that the restart address and the remaining beat count are correct once hold drops. A separate case keeps a second request waiting across the final beat while hold is high, so that a back-to-back address phase is the one held back.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } lbm_state_e;
endpackage

// File: rtl/lbm_cfg_reg.sv
module lbm_cfg_reg #(
  parameter int          CW      = 5,
  parameter logic [CW-1:0] RST_VAL = 5'b00100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [CW-1:0] val_i,
  output logic [CW-1:0] val_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    val_q <= RST_VAL;
    else if (we_i) val_q <= val_i;
  end
endmodule

// File: rtl/lbm_cll_decode.sv
module lbm_cll_decode #(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic [CW-1:0] code_i,
  output logic [AW-1:2] float_mask_o,
  output logic [CW-1:0] burst_len_o
);
  logic legal_nz;
  int   low_bit;

  // A legal nonzero code has exactly one bit set; its position picks the lowest floated bit.
  always_comb begin
    legal_nz = $onehot(code_i);
    low_bit  = AW;
    for (int b = 0; b < CW; b++) begin
      if (code_i[b]) low_bit = b + 2;
    end
    burst_len_o = legal_nz ? code_i : CW'(1);
  end

  for (genvar i = 2; i < AW; i++) begin : g_fl
    assign float_mask_o[i] = legal_nz && (i >= low_bit);
  end
endmodule

// File: rtl/lbm_oe_reg.sv
module lbm_oe_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic [AW-1:2] float_mask_i,
  output logic [AW-1:2] oe_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      oe_q <= '1;
    else if (hold_i) oe_q <= ~float_mask_i;
    else             oe_q <= '1;
  end

  p_oe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(hold_i)) |-> (&oe_q));
  p_oe_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hold_i)) |-> ((oe_q & $past(float_mask_i)) == '0));
endmodule

// File: rtl/lbm_seq.sv
module lbm_seq
  import lbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:2] req_addr_i,
  input  logic [CW-1:0] len_i,
  input  logic          hold_i,
  input  logic          beat_rdy_i,
  input  logic          rdy_ret_i,
  output logic          as_o,
  output logic          cmd_o,
  output logic [AW-1:2] addr_q
);
  lbm_state_e    state_q, state_d;
  logic [CW-1:0] left_q;
  logic          take_beat, last, fin, accept;

  assign last        = (left_q == CW'(1));
  assign take_beat   = (state_q == ST_DATA) && beat_rdy_i;
  assign fin         = take_beat && last;
  assign req_ready_o = (state_q == ST_IDLE) || fin;
  assign accept      = req_valid_i && req_ready_o;
  assign as_o        = (state_q == ST_ADDR) && !hold_i;
  assign cmd_o       = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ADDR;
      ST_ADDR: if (!hold_i) state_d = ST_DATA;
      ST_DATA: begin
        if (take_beat) begin
          if (last)           state_d = accept ? ST_ADDR : ST_IDLE;
          else if (rdy_ret_i) state_d = ST_ADDR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        left_q <= len_i;
        addr_q <= req_addr_i;
      end else if (take_beat) begin
        left_q <= left_q - CW'(1);
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_beat && !last) |=> (addr_q == $past(addr_q) + 1'b1));
  p_suspend_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && hold_i) |=> (state_q == ST_ADDR && $stable(addr_q)));
  p_no_take_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && !beat_rdy_i) |=> $stable(addr_q));
  p_strobe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    as_o |=> (state_q == ST_DATA));
endmodule

// File: rtl/lbm_top.sv
module lbm_top #(
  parameter int AW = 32,
  parameter int CW = 5,
  parameter logic [CW-1:0] CLL_RST = 5'b00100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we_i,
  input  logic [CW-1:0] cfg_cll_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:2] req_addr_i,
  input  logic          hold_i,
  input  logic          beat_rdy_i,
  input  logic          rdy_ret_i,
  output logic          as_o,
  output logic          cmd_o,
  output logic [AW-1:2] addr_o,
  output logic [AW-1:2] addr_oe_o
);
  logic [CW-1:0] cll_q;
  logic [AW-1:2] float_mask;
  logic [CW-1:0] burst_len;

  lbm_cfg_reg #(.CW(CW), .RST_VAL(CLL_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .val_i(cfg_cll_i), .val_q(cll_q));

  lbm_cll_decode #(.AW(AW), .CW(CW)) u_dec (
    .code_i(cll_q), .float_mask_o(float_mask), .burst_len_o(burst_len));

  lbm_oe_reg #(.AW(AW)) u_oe (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .float_mask_i(float_mask),
    .oe_q(addr_oe_o));

  lbm_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .len_i(burst_len), .hold_i(hold_i),
    .beat_rdy_i(beat_rdy_i), .rdy_ret_i(rdy_ret_i), .as_o(as_o), .cmd_o(cmd_o),
    .addr_q(addr_o));

  logic no_float_code;
  assign no_float_code = !$onehot(cll_q);

  p_reserved_nofloat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (no_float_code && $past(no_float_code) && $past(rst_n)) |-> (&addr_oe_o));
endmodule

// File: tb/lbm_top_test.sv
`timescale 1ns/1ps
module lbm_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we_i;
  logic [4:0]  cfg_cll_i;
  logic        req_valid_i;
  logic        req_ready_o;
  logic [31:2] req_addr_i;
  logic        hold_i, beat_rdy_i, rdy_ret_i;
  logic        as_o, cmd_o;
  logic [31:2] addr_o, addr_oe_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  lbm_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_cll_i(cfg_cll_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .hold_i(hold_i), .beat_rdy_i(beat_rdy_i), .rdy_ret_i(rdy_ret_i),
    .as_o(as_o), .cmd_o(cmd_o), .addr_o(addr_o), .addr_oe_o(addr_oe_o));

  // code, lowest floated bit (32 = none), beats
  localparam int NV = 9;
  localparam logic [4:0] V_CODE [NV] = '{5'b00000, 5'b00001, 5'b00010, 5'b00100,
                                         5'b01000, 5'b10000, 5'b00011, 5'b00101, 5'b11111};
  localparam int V_LOW [NV] = '{32, 2, 3, 4, 5, 6, 32, 32, 32};
  localparam int V_LEN [NV] = '{1, 1, 2, 4, 8, 16, 1, 1, 1};

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:2] oe_exp(input int low);
    logic [31:2] m;
    for (int i = 2; i < 32; i++) m[i] = !(i >= low);
    return m;
  endfunction

  task automatic set_cll(input logic [4:0] c);
    @(negedge clk); cfg_we_i = 1'b1; cfg_cll_i = c;
    @(negedge clk); cfg_we_i = 1'b0;
  endtask

  // Runs beats from dword address a until cmd_o drops; returns the count.
  task automatic run_beats(input logic [31:2] a, input string req, output int n);
    n = 0;
    while (cmd_o === 1'b1 && n < 40) begin
      beat_rdy_i = 1'b1;
      #1 chk(addr_o == a + 30'(n), req, 64'(addr_o), 64'(a + 30'(n)));
      @(negedge clk);
      n++;
    end
    beat_rdy_i = 1'b0;
  endtask

  task automatic burst(input logic [31:2] a, input int exp_len, input string req);
    int n;
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk); req_valid_i = 1'b0;
    #1 chk(as_o == 1'b1 && addr_o == a, req, {32'(as_o), 32'(addr_o)}, {32'd1, 32'(a)});
    @(negedge clk);
    run_beats(a, req, n);
    chk(n == exp_len, req, 64'(n), 64'(exp_len));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_we_i = 1'b0; cfg_cll_i = '0; req_valid_i = 1'b0;
    req_addr_i = '0; hold_i = 1'b0; beat_rdy_i = 1'b0; rdy_ret_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(&addr_oe_o, "R3 reset oe", 64'(addr_oe_o), 64'h3fffffff);
    chk(!cmd_o && req_ready_o && !as_o, "R10 reset idle",
        {61'd0, cmd_o, req_ready_o, as_o}, 64'b010);
    // R1: default code 00100
    burst(30'h100, 4, "R1 default length");
    hold_i = 1'b1; @(negedge clk);
    chk(addr_oe_o == oe_exp(4), "R1 default float", 64'(addr_oe_o), 64'(oe_exp(4)));
    hold_i = 1'b0; @(negedge clk);

    // table walk: R2 / R4 / R5
    for (int k = 0; k < NV; k++) begin
      set_cll(V_CODE[k]);
      hold_i = 1'b1;
      #1 chk(&addr_oe_o, "R3 float not before edge", 64'(addr_oe_o), 64'h3fffffff);
      @(negedge clk);
      chk(addr_oe_o == oe_exp(V_LOW[k]), "R2 R4 float mask",
          64'(addr_oe_o), 64'(oe_exp(V_LOW[k])));
      hold_i = 1'b0; @(negedge clk);
      chk(&addr_oe_o, "R3 release", 64'(addr_oe_o), 64'h3fffffff);
      burst(30'h2000 + 30'(k * 64), V_LEN[k], "R5 R4 burst length");
    end

    // R4: reserved code with long hold never floats
    set_cll(5'b00110);
    hold_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(&addr_oe_o, "R4 reserved hold", 64'(addr_oe_o), 64'h3fffffff);
    end
    hold_i = 1'b0; @(negedge clk);

    // R6: hold during data beats
    set_cll(5'b00100);
    req_valid_i = 1'b1; req_addr_i = 30'h400;
    @(negedge clk); req_valid_i = 1'b0;
    @(negedge clk);
    hold_i = 1'b1;
    run_beats(30'h400, "R6 beats under hold", n);
    chk(n == 4, "R6 full length", 64'(n), 64'd4);
    chk(addr_oe_o == oe_exp(4), "R6 floated", 64'(addr_oe_o), 64'(oe_exp(4)));

    // R7: suspended first address cycle (hold still high)
    req_valid_i = 1'b1; req_addr_i = 30'h500;
    @(negedge clk); req_valid_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1 chk(!as_o && cmd_o && addr_o == 30'h500, "R7 suspended",
             {32'(as_o), 32'(addr_o)}, {32'd0, 32'h500});
      @(negedge clk);
    end
    hold_i = 1'b0;
    #1 chk(as_o && addr_o == 30'h500, "R7 resume", {32'(as_o), 32'(addr_o)},
           {32'd1, 32'h500});
    @(negedge clk);
    run_beats(30'h500, "R7 beats", n);
    chk(n == 4, "R7 length", 64'(n), 64'd4);

    // R8: back-to-back request taken on final beat while held
    set_cll(5'b00010);
    req_valid_i = 1'b1; req_addr_i = 30'h600;
    @(negedge clk); req_valid_i = 1'b0;
    @(negedge clk);
    hold_i = 1'b1; beat_rdy_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = 30'h700;
    #1 chk(req_ready_o, "R8 ready on last beat", 64'(req_ready_o), 64'd1);
    @(negedge clk);
    req_valid_i = 1'b0; beat_rdy_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      #1 chk(cmd_o && !as_o && addr_o == 30'h700, "R8 waiting",
             {31'(cmd_o), as_o, 32'(addr_o)}, {31'd1, 1'b0, 32'h700});
      @(negedge clk);
    end
    hold_i = 1'b0;
    #1 chk(as_o && addr_o == 30'h700, "R8 strobe", {32'(as_o), 32'(addr_o)},
           {32'd1, 32'h700});
    @(negedge clk);
    run_beats(30'h700, "R8 beats", n);
    chk(n == 2, "R8 length", 64'(n), 64'd2);

    // R9 / R10: ready-return under hold mid-burst
    set_cll(5'b00100);
    req_valid_i = 1'b1; req_addr_i = 30'h800;
    @(negedge clk); req_valid_i = 1'b0;
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = 30'h900;
    #1 chk(!req_ready_o, "R10 busy", 64'(req_ready_o), 64'd0);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(addr_o == 30'h800, "R10 not taken", 64'(addr_o), 64'h800);
    beat_rdy_i = 1'b1;
    @(negedge clk);
    rdy_ret_i = 1'b1; hold_i = 1'b1;
    @(negedge clk);
    rdy_ret_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      #1 chk(!as_o && cmd_o && addr_o == 30'h802, "R9 restart held",
             {32'(as_o), 32'(addr_o)}, {32'd0, 32'h802});
      @(negedge clk);
    end
    hold_i = 1'b0; beat_rdy_i = 1'b0;
    #1 chk(as_o && addr_o == 30'h802, "R9 restart strobe",
           {32'(as_o), 32'(addr_o)}, {32'd1, 32'h802});
    @(negedge clk);
    run_beats(30'h802, "R9 beats", n);
    chk(n == 2, "R9 remaining", 64'(n), 64'd2);

    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule